// File: doc/BRIEF.md
# Real-Time Clock Source Selector with Write-Once Lock

This block picks the clock that drives the real-time counter. There are three candidates: a slow external crystal oscillator, a slow on-die RC oscillator, and a fast external oscillator divided down by a fixed ratio of 32. A 2-bit choice arrives with a write strobe in the peripheral-bus clock domain. The first non-zero choice is latched and locked. Later writes have no effect until the backup domain is reset. Until a source is chosen, the output clock is held low.

Each candidate belongs to a different power domain, so the block also reports whether the selected clock can be trusted. The slow external source lives in the always-on backup domain and stays trustworthy without main power. The on-die RC source needs the main supply. The divided fast source needs both the main supply and the core regulator. Enabling a source is resynchronised into that source's own clock domain. As a result, the first pulse on the output is always a full-width one.

Top module: `rtcsel_top`

## Requirements
- R1: After the backup reset, `sel_q` reads 00 (00 = no clock), `clk_valid` is 0 and `rtc_clk` stays low.
- R2: A write (`sel_wr` high at a `pclk` edge) of a non-zero value while `sel_q` is 00 is latched into `sel_q` on that edge and locks the choice. While locked, every further write is ignored until a backup reset.
- R3: A write of 00 while `sel_q` is 00 leaves `sel_q` at 00 and unlocked, so a later non-zero write is still accepted.
- R4: With `sel_q` = 01, `rtc_clk` follows the slow external clock. `clk_valid` is 1 whatever the states of `vdd_ok` and `vcore_ok`.
- R5: With `sel_q` = 10, `rtc_clk` follows the slow internal clock, and `clk_valid` equals `vdd_ok`.
- R6: With `sel_q` = 11, `rtc_clk` is the fast clock divided by 32 with a 50 % duty cycle (16 fast periods high, 16 low). `clk_valid` is 1 only when `vdd_ok` and `vcore_ok` are both 1.
- R7: When a source is first enabled, the first high pulse on `rtc_clk` has the full high time of that source.
- R8: A backup reset issued while locked returns `sel_q` to 00, stops `rtc_clk` low and clears the lock.
- R9: Between any two consecutive `pclk` rising edges, `rtc_clk` rises at most once (bus clock at least as fast as the RTC clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral-bus clock for the select write |
| bkp_rst_n | input | 1 | Backup-domain reset, asynchronous, active low |
| lse_clk | input | 1 | Slow external oscillator clock |
| lsi_clk | input | 1 | Slow internal oscillator clock |
| hse_clk | input | 1 | Fast external oscillator clock |
| sel_wr | input | 1 | Write strobe for the select value |
| sel_wdata | input | 2 | Select value to write |
| vdd_ok | input | 1 | Main supply present |
| vcore_ok | input | 1 | Core regulator on |
| rtc_clk | output | 1 | Selected real-time clock |
| sel_q | output | 2 | Latched select value |
| clk_valid | output | 1 | Selected clock is trustworthy in the current power state |

## Verification
The assertions assume two things about the inputs. First, every oscillator runs slower than `pclk`, so `rtc_clk` rises at most once per bus period. Second, writes are only issued after the bus-side reset synchroniser has released. The bench meets the first assumption with a 125 MHz bus clock, slow sources of 100 ns and 70 ns, and a 10 ns fast source that yields a 320 ns divided clock. It meets the second by waiting several bus cycles after every backup reset before it writes. Strobes and supply flags change only on falling `pclk` edges, so each sampled value is stable around the rising edge that latches it.

// File: rtl/rtcsel_pkg.sv
package rtcsel_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_LSE  = 2'b01,
    SRC_LSI  = 2'b10,
    SRC_HSE  = 2'b11
  } rtc_src_e;

  // Trust of the selected clock, given the power state.
  function automatic logic src_trusted(input rtc_src_e src,
                                       input logic vdd, input logic vcore);
    case (src)
      SRC_LSE: src_trusted = 1'b1;
      SRC_LSI: src_trusted = vdd;
      SRC_HSE: src_trusted = vdd & vcore;
      default: src_trusted = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rtcsel_rstsync.sv
module rtcsel_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtcsel_lsgate.sv
module rtcsel_lsgate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_req,
  output logic gclk
);
  logic              rst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic              en_fall_q;
  logic              en_fall_d;

  rtcsel_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .srst_n(rst_n)
  );

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], en_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // Enable changes only while the clock is low: no truncated pulse.
  always_comb begin
    en_fall_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_fall_q <= 1'b0;
    else        en_fall_q <= en_fall_d;
  end

  assign gclk = clk & en_fall_q;
endmodule

// File: rtl/rtcsel_hsediv.sv
module rtcsel_hsediv #(
  parameter int DIV         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_req,
  output logic dclk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic                   rst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   run;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_d;
  logic                   dclk_q;
  logic                   dclk_d;
  logic                   cnt_en;
  logic                   dclk_en;

  rtcsel_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .srst_n(rst_n)
  );

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], en_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[SYNC_STAGES-1];

  // Counter advances only while the divided source is selected.
  always_comb begin
    cnt_en  = run;
    dclk_en = run && (cnt_q == LAST);
    cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    dclk_d  = ~dclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dclk_q <= 1'b0;
    else if (dclk_en) dclk_q <= dclk_d;
  end

  assign dclk = dclk_q;
endmodule

// File: rtl/rtcsel_top.sv
module rtcsel_top
  import rtcsel_pkg::*;
#(
  parameter int HSE_DIV     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       pclk,
  input  logic       bkp_rst_n,
  input  logic       lse_clk,
  input  logic       lsi_clk,
  input  logic       hse_clk,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       vdd_ok,
  input  logic       vcore_ok,
  output logic       rtc_clk,
  output logic [1:0] sel_q,
  output logic       clk_valid
);
  localparam int NUM_LS = 2;

  logic       p_rst_n;
  rtc_src_e   src_q;
  rtc_src_e   src_d;
  logic       src_en;
  logic       locked;
  logic [NUM_LS-1:0] ls_clk;
  logic [NUM_LS-1:0] ls_req;
  logic [NUM_LS-1:0] ls_gclk;
  logic       hse_req;
  logic       hse_dclk;

  rtcsel_rstsync #(.STAGES(SYNC_STAGES)) u_prst (
    .clk(pclk), .arst_n(bkp_rst_n), .srst_n(p_rst_n)
  );

  // Write-once select register in the bus domain.
  assign locked = (src_q != SRC_NONE);

  always_comb begin
    src_en = sel_wr && !locked;
    src_d  = rtc_src_e'(sel_wdata);
  end

  always_ff @(posedge pclk or negedge p_rst_n) begin
    if (!p_rst_n)    src_q <= SRC_NONE;
    else if (src_en) src_q <= src_d;
  end

  assign sel_q     = src_q;
  assign clk_valid = src_trusted(src_q, vdd_ok, vcore_ok);

  // Slow sources: index 0 external, index 1 internal.
  assign ls_clk = {lsi_clk, lse_clk};

  for (genvar i = 0; i < NUM_LS; i++) begin : g_ls
    assign ls_req[i] = (src_q == rtc_src_e'(i + 1));

    rtcsel_lsgate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(ls_clk[i]), .arst_n(bkp_rst_n),
      .en_req(ls_req[i]), .gclk(ls_gclk[i])
    );
  end

  assign hse_req = (src_q == SRC_HSE);

  rtcsel_hsediv #(.DIV(HSE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk(hse_clk), .arst_n(bkp_rst_n),
    .en_req(hse_req), .dclk(hse_dclk)
  );

  // At most one leg is ever active, since the choice is locked.
  assign rtc_clk = (|ls_gclk) | hse_dclk;
endmodule

// File: rtl/rtcsel_chk.sv
module rtcsel_chk (
  input logic       pclk,
  input logic       rst_n,
  input logic       rtc_clk,
  input logic       sel_wr,
  input logic [1:0] sel_wdata,
  input logic [1:0] sel_q,
  input logic       vdd_ok,
  input logic       vcore_ok,
  input logic       clk_valid
);
  logic [7:0] rtc_edges;
  logic [7:0] rtc_seen;

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) rtc_edges <= '0;
    else        rtc_edges <= rtc_edges + 8'd1;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) rtc_seen <= '0;
    else        rtc_seen <= rtc_edges;
  end

  assert_no_clock_unselected_R1: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q == 2'b00) |-> !rtc_clk);

  assert_first_write_taken_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_wr && sel_q == 2'b00 && sel_wdata != 2'b00) |=> (sel_q == $past(sel_wdata)));

  assert_lock_holds_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q != 2'b00) |=> $stable(sel_q));

  assert_zero_write_unlocked_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q == 2'b00 && sel_wr && sel_wdata == 2'b00) |=> (sel_q == 2'b00));

  assert_lse_trusted_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q == 2'b01) |-> clk_valid);

  assert_lsi_needs_vdd_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q == 2'b10 && !vdd_ok) |-> !clk_valid);

  assert_hse_needs_core_R6: assert property (@(posedge pclk) disable iff (!rst_n)
    (sel_q == 2'b11 && !(vdd_ok && vcore_ok)) |-> !clk_valid);

  assert_bus_clock_faster_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    (8'(rtc_edges - rtc_seen) <= 8'd1));
endmodule

bind rtcsel_top rtcsel_chk u_chk (
  .pclk(pclk), .rst_n(p_rst_n), .rtc_clk(rtc_clk),
  .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_q(sel_q),
  .vdd_ok(vdd_ok), .vcore_ok(vcore_ok), .clk_valid(clk_valid)
);

// File: tb/sim_rtcsel_top.sv
`timescale 1ns/1ps
module sim_rtcsel_top;
  logic       pclk = 0, lse_clk = 0, lsi_clk = 0, hse_clk = 0;
  logic       bkp_rst_n = 0;
  logic       sel_wr = 0;
  logic [1:0] sel_wdata = 0;
  logic       vdd_ok = 1, vcore_ok = 1;
  logic       rtc_clk, clk_valid;
  logic [1:0] sel_q;
  int errors = 0, checks = 0;
  real t0, t1, t2;

  always #4  pclk    = ~pclk;
  always #50 lse_clk = ~lse_clk;
  always #35 lsi_clk = ~lsi_clk;
  always #5  hse_clk = ~hse_clk;

  rtcsel_top u0 (
    .pclk(pclk), .bkp_rst_n(bkp_rst_n), .lse_clk(lse_clk), .lsi_clk(lsi_clk),
    .hse_clk(hse_clk), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .vdd_ok(vdd_ok),
    .vcore_ok(vcore_ok), .rtc_clk(rtc_clk), .sel_q(sel_q), .clk_valid(clk_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge pclk); bkp_rst_n = 0;
    #20; bkp_rst_n = 1;
    repeat (5) @(negedge pclk);
  endtask

  task automatic do_write(input logic [1:0] v);
    @(negedge pclk); sel_wr = 1; sel_wdata = v;
    @(negedge pclk); sel_wr = 0; sel_wdata = 0;
  endtask

  task automatic stays_low(input int cyc, input string req);
    int highs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge pclk); if (rtc_clk) highs++;
    end
    chk(highs == 0, req, "rtc_clk high samples while unselected", highs, 0);
  endtask

  // Full period and high time of the next rtc_clk cycle, in ns.
  task automatic measure(output int per, output int hi);
    @(posedge rtc_clk); t0 = $realtime;
    @(negedge rtc_clk); t1 = $realtime;
    @(posedge rtc_clk); t2 = $realtime;
    per = $rtoi(t2 - t0 + 0.5);
    hi  = $rtoi(t1 - t0 + 0.5);
  endtask

  task automatic first_pulse(input int exp_hi, input string req);
    @(posedge rtc_clk); t0 = $realtime;
    @(negedge rtc_clk); t1 = $realtime;
    chk($rtoi(t1 - t0 + 0.5) == exp_hi, req, "first pulse width ns",
        $rtoi(t1 - t0 + 0.5), exp_hi);
  endtask

  task automatic valid_is(input logic v, input logic c, input logic exp, input string req);
    @(negedge pclk); vdd_ok = v; vcore_ok = c;
    @(negedge pclk);
    chk(clk_valid == exp, req, "clk_valid", clk_valid, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(sel_q == 2'b00, "R1", "sel_q after reset", sel_q, 0);
    chk(clk_valid == 1'b0, "R1", "clk_valid after reset", clk_valid, 0);
    stays_low(100, "R1");
  endtask

  task automatic t_zero_write();
    do_write(2'b00);
    chk(sel_q == 2'b00, "R3", "sel_q after zero write", sel_q, 0);
    stays_low(60, "R3");
  endtask

  task automatic t_lse();
    int per, hi;
    do_write(2'b01);
    chk(sel_q == 2'b01, "R3", "non-zero accepted after zero write", sel_q, 1);
    first_pulse(50, "R7");
    measure(per, hi);
    chk(per == 100, "R4", "lse period ns", per, 100);
    chk(hi == 50, "R4", "lse high ns", hi, 50);
    chk(per >= 8, "R9", "rtc period not below bus period", per, 8);
    do_write(2'b10);
    chk(sel_q == 2'b01, "R2", "write 10 ignored while locked", sel_q, 1);
    do_write(2'b11);
    do_write(2'b00);
    chk(sel_q == 2'b01, "R2", "writes 11/00 ignored while locked", sel_q, 1);
    measure(per, hi);
    chk(per == 100, "R2", "output still lse after ignored writes", per, 100);
    valid_is(1'b0, 1'b0, 1'b1, "R4");
    valid_is(1'b1, 1'b0, 1'b1, "R4");
    valid_is(1'b1, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_backup_reset();
    do_reset();
    chk(sel_q == 2'b00, "R8", "sel_q after backup reset", sel_q, 0);
    chk(clk_valid == 1'b0, "R8", "clk_valid after backup reset", clk_valid, 0);
    stays_low(60, "R8");
  endtask

  task automatic t_lsi();
    int per, hi;
    do_write(2'b10);
    chk(sel_q == 2'b10, "R8", "write accepted after backup reset", sel_q, 2);
    first_pulse(35, "R7");
    measure(per, hi);
    chk(per == 70, "R5", "lsi period ns", per, 70);
    chk(hi == 35, "R5", "lsi high ns", hi, 35);
    valid_is(1'b1, 1'b1, 1'b1, "R5");
    valid_is(1'b0, 1'b1, 1'b0, "R5");
    valid_is(1'b1, 1'b0, 1'b1, "R5");
    valid_is(1'b1, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_hse();
    int per, hi;
    do_reset();
    stays_low(40, "R6");
    do_write(2'b11);
    chk(sel_q == 2'b11, "R6", "sel_q hse", sel_q, 3);
    first_pulse(160, "R7");
    measure(per, hi);
    chk(per == 320, "R6", "hse/32 period ns", per, 320);
    chk(hi == 160, "R6", "hse/32 high ns", hi, 160);
    valid_is(1'b1, 1'b1, 1'b1, "R6");
    valid_is(1'b0, 1'b1, 1'b0, "R6");
    valid_is(1'b1, 1'b0, 1'b0, "R6");
    valid_is(1'b0, 1'b0, 1'b0, "R6");
    valid_is(1'b1, 1'b1, 1'b1, "R6");
  endtask

  initial begin
    t_reset_state();
    t_zero_write();
    t_lse();
    t_backup_reset();
    t_lsi();
    t_hse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule